// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit register front end of one interrupt domain. A requester presents a word-aligned byte offset with a read or write request. The block decodes the offset into one of several register groups and performs the matching action on the per-source state it holds. It answers every request one clock later with read data and a status code.

The register groups are as follows. A domain control word holds the domain-wide interrupt enable. There are two per-source arrays, one for configuration and one for target. Pending and enable bitmaps each have a setting view and a clearing view. Registers that set or clear the pending or enable bit of one source, named by number, sit beside the bitmaps. Set-pending-by-number also comes in a byte-reversed form. The last register is a message-generation word.

Source 0 does not exist. Its state bits never become 1, and the per-source arrays start at source 1. The pending vector, the enable vector and the domain enable are brought out so that the delivery logic next to this block can use them.

Top module: `intc_reg_decoder`

## Requirements
- R1: An offset whose two low bits are not 00 gets status 1 (unaligned), with read data 0, and a write to it changes no state.
- R2: An aligned offset that hits no register gets status 2 (no register), with read data 0. This includes array slots past source NSRC, bitmap words at or past the bitmap word count NW = ceil((NSRC+1)/32), and offsets between groups. A write to such an offset changes no state.
- R3: Each request cycle is followed, in the next cycle, by exactly one response with rsp_valid high. Status 0 means success. rsp_valid is low in a cycle after no request.
- R4: The domain control word is at offset 0x0000. A read returns 0x4 (bit 2, delivery mode, always 1) OR'd with the stored enable in bit 8. A write stores only wdata bit 8, and ie_o shows that stored bit.
- R5: Source i (1..NSRC) has its configuration word at 0x0004 + 4*(i-1) and its target word at 0x3004 + 4*(i-1). Configuration keeps the low CFG_W bits of a write, and reads them back zero-extended. Target keeps and reads back all 32 bits.
- R6: Set-pending bitmap word k is at 0x1C00 + 4k, and its bit b stands for source 32k+b. Writing 1 to a bit sets that pending bit, and writing 0 does nothing. Source 0 is never set. A read returns the current pending bits of that word, and pend_o shows them.
- R7: Clear-pending bitmap word k is at 0x1D00 + 4k. Writing 1 to a bit clears that pending bit, and writing 0 does nothing. A read returns 0.
- R8: The set-enable bitmap is at 0x1E00 + 4k and the clear-enable bitmap at 0x1F00 + 4k. They act on the enable bits the way R6 and R7 act on pending. The set view reads the current enable bits, the clear view reads 0, and en_o shows the enable bits.
- R9: A write of number n to 0x1CDC sets the pending bit of source n. A write to 0x1DDC clears it, a write to 0x1EDC sets the enable bit of source n, and a write to 0x1FDC clears it. A number of 0 or above NSRC is ignored, and these offsets read 0.
- R10: A write of n to 0x2000 sets the pending bit of source n. A write to 0x2004 does the same after reversing the byte order of the written word. Out-of-range numbers are ignored as in R9, and both offsets read 0.
- R11: The message-generation word is at 0x3000. A write stores wdata with bits 17:12 cleared, and a read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset inside the domain |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_err | output | 2 | 0 ok, 1 unaligned, 2 no register |
| rsp_rdata | output | 32 | Read data, 0 on error and for writes to write-only views |
| ie_o | output | 1 | Stored domain interrupt enable |
| pend_o | output | NSRC+1 | Pending bit per source, bit 0 always 0 |
| en_o | output | NSRC+1 | Enable bit per source, bit 0 always 0 |

## Verification
The bench builds the block with NSRC = 40, CFG_W = 11 and AW = 15. This gives two bitmap words, and the second word is only partly filled (sources 32 to 40). Every source slot in both arrays can be written and read back. The by-number registers are swept over numbers 0 to 63, so the zero number, the last valid source and numbers past the end are all exercised. Bit 0 of word 0 and the unused upper bits of word 1 are driven with 1s to show they are dropped.

// File: rtl/intc_reg_decoder.sv
module intc_reg_decoder #(
  parameter int NSRC  = 63,
  parameter int CFG_W = 11,
  parameter int AW    = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [1:0]      rsp_err,
  output logic [31:0]     rsp_rdata,
  output logic            ie_o,
  output logic [NSRC:0]   pend_o,
  output logic [NSRC:0]   en_o
);
  localparam int NIRQ = NSRC + 1;
  localparam int NW   = (NIRQ + 31) / 32;
  localparam int BW   = NW * 32;
  localparam int IW   = $clog2(NIRQ);

  localparam logic [31:0] A_DOM  = 32'h0000;
  localparam logic [31:0] A_CFG  = 32'h0004;
  localparam logic [31:0] A_SIP  = 32'h1C00;
  localparam logic [31:0] A_SIPN = 32'h1CDC;
  localparam logic [31:0] A_CIP  = 32'h1D00;
  localparam logic [31:0] A_CIPN = 32'h1DDC;
  localparam logic [31:0] A_SIE  = 32'h1E00;
  localparam logic [31:0] A_SIEN = 32'h1EDC;
  localparam logic [31:0] A_CIE  = 32'h1F00;
  localparam logic [31:0] A_CIEN = 32'h1FDC;
  localparam logic [31:0] A_LE   = 32'h2000;
  localparam logic [31:0] A_BE   = 32'h2004;
  localparam logic [31:0] A_MSI  = 32'h3000;
  localparam logic [31:0] A_TGT  = 32'h3004;
  localparam logic [31:0] MSI_KEEP = ~32'h0003_F000;

  function automatic logic in_range(input logic [31:0] x, input logic [31:0] base, input int n);
    return (x >= base) && (x < base + 32'(4 * n));
  endfunction

  function automatic logic [NIRQ-1:0] one_src(input logic [31:0] n);
    if (n >= 32'd1 && n <= 32'(NSRC)) return NIRQ'(1) << n;
    return '0;
  endfunction

  logic [31:0] a;
  logic        al, wr;
  assign a  = 32'(req_addr);
  assign al = (req_addr[1:0] == 2'b00);
  assign wr = req_valid && req_write && al;

  logic hit_dom, hit_cfg, hit_tgt, hit_sip, hit_cip, hit_sie, hit_cie;
  logic hit_sipn, hit_cipn, hit_sien, hit_cien, hit_le, hit_be, hit_msi, hit_wo;
  assign hit_dom  = (a == A_DOM);
  assign hit_cfg  = in_range(a, A_CFG, NSRC);
  assign hit_tgt  = in_range(a, A_TGT, NSRC);
  assign hit_sip  = in_range(a, A_SIP, NW);
  assign hit_cip  = in_range(a, A_CIP, NW);
  assign hit_sie  = in_range(a, A_SIE, NW);
  assign hit_cie  = in_range(a, A_CIE, NW);
  assign hit_sipn = (a == A_SIPN);
  assign hit_cipn = (a == A_CIPN);
  assign hit_sien = (a == A_SIEN);
  assign hit_cien = (a == A_CIEN);
  assign hit_le   = (a == A_LE);
  assign hit_be   = (a == A_BE);
  assign hit_msi  = (a == A_MSI);
  assign hit_wo   = hit_cip | hit_cie | hit_sipn | hit_cipn | hit_sien | hit_cien | hit_le | hit_be;

  logic [IW-1:0] src_sel;
  assign src_sel = hit_cfg ? IW'(((a - A_CFG) >> 2) + 32'd1)
                           : IW'(((a - A_TGT) >> 2) + 32'd1);

  logic [31:0]     bm_k;
  logic [BW-1:0]   bm_wide;
  logic [NIRQ-1:0] bm_src;
  logic [31:0]     be_num;
  assign bm_k    = (a & 32'h0000_00FF) >> 2;
  assign bm_wide = BW'(req_wdata) << (bm_k * 32);
  assign bm_src  = bm_wide[NIRQ-1:0] & ~NIRQ'(1);
  assign be_num  = {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};

  logic [NIRQ-1:0] set_p, clr_p, set_e, clr_e;
  assign set_p = (wr && hit_sip ? bm_src : '0)
               | (wr && (hit_sipn || hit_le) ? one_src(req_wdata) : '0)
               | (wr && hit_be ? one_src(be_num) : '0);
  assign clr_p = (wr && hit_cip ? bm_src : '0) | (wr && hit_cipn ? one_src(req_wdata) : '0);
  assign set_e = (wr && hit_sie ? bm_src : '0) | (wr && hit_sien ? one_src(req_wdata) : '0);
  assign clr_e = (wr && hit_cie ? bm_src : '0) | (wr && hit_cien ? one_src(req_wdata) : '0);

  logic [NIRQ-1:0]  pend_q, en_q;
  logic             ie_q;
  logic [31:0]      msi_q;
  logic [CFG_W-1:0] cfg_q [NIRQ];
  logic [31:0]      tgt_q [NIRQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      ie_q   <= 1'b0;
      msi_q  <= '0;
      for (int i = 0; i < NIRQ; i++) begin
        cfg_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else begin
      pend_q <= (pend_q | set_p) & ~clr_p;
      en_q   <= (en_q | set_e) & ~clr_e;
      if (wr && hit_dom) ie_q <= req_wdata[8];
      if (wr && hit_msi) msi_q <= req_wdata & MSI_KEEP;
      if (wr && hit_cfg) cfg_q[src_sel] <= req_wdata[CFG_W-1:0];
      if (wr && hit_tgt) tgt_q[src_sel] <= req_wdata;
    end
  end

  logic [BW-1:0] pend_w, en_w;
  assign pend_w = BW'(pend_q) >> (bm_k * 32);
  assign en_w   = BW'(en_q) >> (bm_k * 32);

  logic [31:0] rd;
  logic [1:0]  er;
  always_comb begin
    rd = '0;
    er = 2'd0;
    if (!al)           er = 2'd1;
    else if (hit_dom)  rd = {23'd0, ie_q, 8'h04};
    else if (hit_cfg)  rd = 32'(cfg_q[src_sel]);
    else if (hit_tgt)  rd = tgt_q[src_sel];
    else if (hit_sip)  rd = pend_w[31:0];
    else if (hit_sie)  rd = en_w[31:0];
    else if (hit_msi)  rd = msi_q;
    else if (!hit_wo)  er = 2'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 2'd0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid ? er : 2'd0;
      rsp_rdata <= req_valid ? rd : '0;
    end
  end

  assign ie_o   = ie_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/intc_reg_decoder_chk.sv
module intc_reg_decoder_chk #(
  parameter int NSRC = 63,
  parameter int AW   = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [1:0]    rsp_err,
  input logic [31:0]   rsp_rdata,
  input logic          ie_o,
  input logic [NSRC:0] pend_o,
  input logic [NSRC:0] en_o
);
  // R3
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> rsp_rdata == 32'd0);
  // R1
  unaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err == 2'd1);
  // R1
  unaligned_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> ($stable(pend_o) && $stable(en_o) && $stable(ie_o)));
  // R4
  dm_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == '0) |=> (rsp_rdata[2] && rsp_err == 2'd0));
  // R4
  ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == '0) |=> $stable(ie_o));
  // R6
  src0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o[0] && !en_o[0]));
  // R6
  no_req_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(pend_o) && $stable(en_o)));
endmodule

bind intc_reg_decoder intc_reg_decoder_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .ie_o(ie_o), .pend_o(pend_o), .en_o(en_o)
);

// File: tb/test_intc_reg_decoder.sv
module test_intc_reg_decoder;
  localparam int NSRC = 40;
  localparam int NIRQ = NSRC + 1;
  localparam int NW   = (NIRQ + 31) / 32;
  localparam int AW   = 15;
  localparam int CFG_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, ie_o;
  logic [1:0] rsp_err;
  logic [31:0] rsp_rdata;
  logic [NSRC:0] pend_o, en_o;

  always #10 clk = ~clk;

  intc_reg_decoder #(.NSRC(NSRC), .CFG_W(CFG_W), .AW(AW)) i_intc_reg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ie_o(ie_o), .pend_o(pend_o), .en_o(en_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [1:0]  got_e;
  logic [31:0] got_d;
  logic [NIRQ-1:0] pm = '0, em = '0;
  logic [31:0] cfg_m [NIRQ];
  logic [31:0] tgt_m [NIRQ];

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // one request; response sampled at the next falling edge (R3)
  task automatic xfer(input logic w, input logic [31:0] ad, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = AW'(ad); req_wdata = d;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R3 rsp_valid", 64'(rsp_valid), 64'd1);
    got_e = rsp_err; got_d = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_exp(input logic [31:0] ad, input logic [31:0] exp, input logic [1:0] ee, input string r);
    xfer(1'b0, ad, 32'd0);
    chk(got_e == ee && got_d == exp, r, {30'd0, got_e, got_d}, {30'd0, ee, exp});
  endtask

  function automatic logic [31:0] word_of(input logic [NIRQ-1:0] v, input int k);
    logic [63:0] t;
    t = 64'(v) >> (32 * k);
    return t[31:0];
  endfunction

  function automatic logic [NIRQ-1:0] bm_bits(input int k, input logic [31:0] d);
    logic [NIRQ-1:0] r;
    r = '0;
    for (int s = 1; s < NIRQ; s++) if (s / 32 == k && d[s % 32]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [NIRQ-1:0] num_bit(input logic [31:0] n);
    logic [NIRQ-1:0] r;
    r = '0;
    for (int s = 1; s < NIRQ; s++) if (n == 32'(s)) r[s] = 1'b1;
    return r;
  endfunction

  task automatic clear_all_pend();
    for (int k = 0; k < NW; k++) xfer(1'b1, 32'h1D00 + 32'(4 * k), 32'hFFFF_FFFF);
    pm = '0;
    chk(64'(pend_o) == 64'(pm), "R7 clear all", 64'(pend_o), 64'(pm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) begin cfg_m[i] = '0; tgt_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(pend_o == '0 && en_o == '0, "R6 reset vectors", {pend_o, en_o}, 0);
    chk(ie_o == 1'b0, "R4 reset ie", 64'(ie_o), 0);
    chk(rsp_valid == 1'b0, "R3 idle", 64'(rsp_valid), 0);
    rd_exp(32'h0, 32'h4, 2'd0, "R4 reset read");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3 idle after read", 64'(rsp_valid), 0);

    // R4 domain control
    xfer(1'b1, 32'h0, 32'hFFFF_FFFF);
    chk(ie_o == 1'b1, "R4 ie set", 64'(ie_o), 1);
    rd_exp(32'h0, 32'h104, 2'd0, "R4 read enabled");
    xfer(1'b1, 32'h0, 32'hFFFF_FEFF);
    chk(ie_o == 1'b0, "R4 ie clear", 64'(ie_o), 0);
    rd_exp(32'h0, 32'h4, 2'd0, "R4 read disabled");

    // R5 arrays, full sweep
    for (int i = 1; i <= NSRC; i++) begin
      logic [31:0] dc, dt;
      dc = 32'hABCD_0000 ^ 32'(i * 37);
      dt = 32'(i) * 32'h0102_0305 ^ 32'hF0F0_0000;
      xfer(1'b1, 32'(4 * i), dc);
      chk(got_e == 2'd0, "R5 cfg write ok", 64'(got_e), 0);
      xfer(1'b1, 32'h3000 + 32'(4 * i), dt);
      cfg_m[i] = dc & ((32'd1 << CFG_W) - 32'd1);
      tgt_m[i] = dt;
    end
    for (int i = 1; i <= NSRC; i++) begin
      rd_exp(32'(4 * i), cfg_m[i], 2'd0, "R5 cfg readback");
      rd_exp(32'h3000 + 32'(4 * i), tgt_m[i], 2'd0, "R5 target readback");
    end

    // R2 no register
    rd_exp(32'(4 * (NSRC + 1)), 32'h0, 2'd2, "R2 cfg past end");
    rd_exp(32'h3000 + 32'(4 * (NSRC + 1)), 32'h0, 2'd2, "R2 target past end");
    rd_exp(32'h1C00 + 32'(4 * NW), 32'h0, 2'd2, "R2 bitmap past end");
    rd_exp(32'h1800, 32'h0, 2'd2, "R2 gap");
    rd_exp(32'h2008, 32'h0, 2'd2, "R2 gap after BE");
    xfer(1'b1, 32'h1C00 + 32'(4 * NW), 32'hFFFF_FFFF);
    chk(got_e == 2'd2 && pend_o == '0, "R2 write ignored", {62'd0, got_e}, 64'd2);
    xfer(1'b1, 32'h1E00 + 32'(4 * NW), 32'hFFFF_FFFF);
    chk(en_o == '0, "R2 enable write ignored", 64'(en_o), 0);

    // R1 unaligned
    for (int b = 0; b < 6; b++) begin
      logic [31:0] base;
      case (b)
        0: base = 32'h0000; 1: base = 32'h0004; 2: base = 32'h1C00;
        3: base = 32'h1E00; 4: base = 32'h2000; default: base = 32'h3000;
      endcase
      for (int o = 1; o < 4; o++) begin
        rd_exp(base + 32'(o), 32'h0, 2'd1, "R1 unaligned read");
        xfer(1'b1, base + 32'(o), 32'hFFFF_FFFF);
        chk(got_e == 2'd1 && got_d == 0, "R1 unaligned write", {30'd0, got_e, got_d}, 64'h1_0000_0000);
        chk(pend_o == '0 && en_o == '0 && ie_o == 1'b0, "R1 no state change", {pend_o, en_o}, 0);
      end
    end
    rd_exp(32'h0004, cfg_m[1], 2'd0, "R1 cfg untouched");
    rd_exp(32'h3000, 32'h0, 2'd0, "R1 msi untouched");

    // R6 set-pending bitmap
    for (int k = 0; k < NW; k++) begin
      xfer(1'b1, 32'h1C00 + 32'(4 * k), 32'h0);
      chk(pend_o == pm, "R6 zero write", 64'(pend_o), 64'(pm));
    end
    xfer(1'b1, 32'h1C00, 32'h8000_0011);
    pm |= bm_bits(0, 32'h8000_0011);
    chk(pend_o == pm, "R6 set word0", 64'(pend_o), 64'(pm));
    xfer(1'b1, 32'h1C04, 32'hFFFF_FFFF);
    pm |= bm_bits(1, 32'hFFFF_FFFF);
    chk(pend_o == pm, "R6 set word1 partial", 64'(pend_o), 64'(pm));
    xfer(1'b1, 32'h1C00, 32'hFFFF_FFFF);
    pm |= bm_bits(0, 32'hFFFF_FFFF);
    chk(pend_o == pm && pend_o[0] == 1'b0, "R6 source 0 kept clear", 64'(pend_o), 64'(pm));
    for (int k = 0; k < NW; k++) rd_exp(32'h1C00 + 32'(4 * k), word_of(pm, k), 2'd0, "R6 read word");

    // R7 clear-pending bitmap
    xfer(1'b1, 32'h1D00, 32'h0F0F_0F0F);
    pm &= ~bm_bits(0, 32'h0F0F_0F0F);
    chk(pend_o == pm, "R7 clear word0", 64'(pend_o), 64'(pm));
    xfer(1'b1, 32'h1D04, 32'h0000_00AA);
    pm &= ~bm_bits(1, 32'h0000_00AA);
    chk(pend_o == pm, "R7 clear word1", 64'(pend_o), 64'(pm));
    for (int k = 0; k < NW; k++) begin
      rd_exp(32'h1D00 + 32'(4 * k), 32'h0, 2'd0, "R7 reads zero");
      rd_exp(32'h1C00 + 32'(4 * k), word_of(pm, k), 2'd0, "R7 set view after clear");
    end

    // R8 enable bitmaps
    xfer(1'b1, 32'h1E00, 32'h1234_5679);
    em |= bm_bits(0, 32'h1234_5679);
    xfer(1'b1, 32'h1E04, 32'h0000_FFFF);
    em |= bm_bits(1, 32'h0000_FFFF);
    chk(en_o == em, "R8 set enable", 64'(en_o), 64'(em));
    for (int k = 0; k < NW; k++) rd_exp(32'h1E00 + 32'(4 * k), word_of(em, k), 2'd0, "R8 read enable");
    xfer(1'b1, 32'h1F00, 32'hFFFF_0000);
    em &= ~bm_bits(0, 32'hFFFF_0000);
    xfer(1'b1, 32'h1F04, 32'h0000_0101);
    em &= ~bm_bits(1, 32'h0000_0101);
    chk(en_o == em && pend_o == pm, "R8 clear enable", 64'(en_o), 64'(em));
    rd_exp(32'h1F00, 32'h0, 2'd0, "R8 clear view reads zero");

    // R9 by number
    for (int k = 0; k < NW; k++) xfer(1'b1, 32'h1F00 + 32'(4 * k), 32'hFFFF_FFFF);
    em = '0;
    clear_all_pend();
    for (int n = 0; n < 64; n++) begin
      xfer(1'b1, 32'h1EDC, 32'(n));
      em |= num_bit(32'(n));
      chk(en_o == em, "R9 set enable by number", 64'(en_o), 64'(em));
      xfer(1'b1, 32'h1CDC, 32'(n));
      pm |= num_bit(32'(n));
      chk(pend_o == pm, "R9 set pending by number", 64'(pend_o), 64'(pm));
    end
    xfer(1'b1, 32'h1DDC, 32'h0001_0001);
    chk(pend_o == pm, "R9 big number ignored", 64'(pend_o), 64'(pm));
    for (int n = 0; n < 64; n += 2) begin
      xfer(1'b1, 32'h1FDC, 32'(n));
      em &= ~num_bit(32'(n));
      xfer(1'b1, 32'h1DDC, 32'(n + 1));
      pm &= ~num_bit(32'(n + 1));
      chk(en_o == em && pend_o == pm, "R9 clear by number", {pend_o, en_o}, {pm, em});
    end
    rd_exp(32'h1CDC, 32'h0, 2'd0, "R9 reads zero set-pend");
    rd_exp(32'h1DDC, 32'h0, 2'd0, "R9 reads zero clr-pend");
    rd_exp(32'h1EDC, 32'h0, 2'd0, "R9 reads zero set-en");
    rd_exp(32'h1FDC, 32'h0, 2'd0, "R9 reads zero clr-en");

    // R10 byte-order variants
    clear_all_pend();
    for (int n = 0; n < 46; n += 3) begin
      xfer(1'b1, 32'h2000, 32'(n));
      pm |= num_bit(32'(n));
      chk(pend_o == pm, "R10 plain order", 64'(pend_o), 64'(pm));
    end
    clear_all_pend();
    for (int n = 0; n < 46; n += 3) begin
      logic [31:0] v;
      v = 32'(n);
      xfer(1'b1, 32'h2004, {v[7:0], v[15:8], v[23:16], v[31:24]});
      pm |= num_bit(v);
      chk(pend_o == pm, "R10 reversed order", 64'(pend_o), 64'(pm));
    end
    clear_all_pend();
    xfer(1'b1, 32'h2000, 32'h0500_0000);
    chk(pend_o == pm, "R10 plain ignores reversed value", 64'(pend_o), 64'(pm));
    xfer(1'b1, 32'h2004, 32'h0500_0000);
    pm |= num_bit(32'd5);
    chk(pend_o == pm, "R10 reversed selects source 5", 64'(pend_o), 64'(pm));
    rd_exp(32'h2000, 32'h0, 2'd0, "R10 reads zero");
    rd_exp(32'h2004, 32'h0, 2'd0, "R10 reads zero reversed");

    // R11 message-generation word
    xfer(1'b1, 32'h3000, 32'hFFFF_FFFF);
    rd_exp(32'h3000, 32'hFFFF_FFFF & ~(32'h3F << 12), 2'd0, "R11 all ones");
    xfer(1'b1, 32'h3000, 32'h1234_5678);
    rd_exp(32'h3000, 32'h1234_5678 & ~(32'h3F << 12), 2'd0, "R11 pattern");
    rd_exp(32'h3004, tgt_m[1], 2'd0, "R11 target 1 untouched");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule